// File: doc/BRIEF.md
# Address Window Decoder

This block sorts bus addresses from a data-mover engine into up to eight address windows. Software writes each window's base, size mask and attribute, plus a shared control word, through a small register port. For every lookup request the block compares the address against all enabled windows at once. It picks the lowest-numbered match and checks that window's access permission. One cycle later it returns either a hit, with the window index and its 8-bit target attribute, or a miss.

The window size is a mask counted in 64 KB units, so a window always spans a whole number of 64 KB blocks. The attribute code is copied as it stands from the base register. A chip-select target normally carries one cleared bit among set bits (0x0E, 0x0D, 0x0B, 0x07), and an on-chip SRAM target carries 0x1F.

Top module: `addrwin_decoder`

## Requirements
- R1: After reset, every register reads zero and every lookup returns a miss.
- R2: Window i can hit only while bit i of the control word (select 0) is set. With the control word at zero, every lookup misses.
- R3: The size-mask register holds (size/64 KB - 1) in bits [31:16]. An address matches window i when `((addr ^ base) & ~{mask[31:16], 16'hFFFF}) == 0`. A 64 KB window therefore covers base..base+0xFFFF, and the next address misses.
- R4: On a hit, `res_attr` equals bits [15:8] of the winning window's base register, and `res_win` is its index.
- R5: When several enabled windows match, the lowest index wins.
- R6: On a miss, `res_win` and `res_attr` are both zero.
- R7: Control bits [17+2i:16+2i] hold window i's permission: the lower bit allows reads and the upper bit allows writes. If the winning window does not allow the access type, the result is a miss. The lookup does not fall through to a higher-index window.
- R8: `res_valid` is high in exactly the cycle after a cycle with `lk_valid` high. Back-to-back requests give back-to-back results.
- R9: Registers read back as written. The register map is: select 0 is control, select 8+i is base i, select 16+i is mask i. Any other select reads zero, and a write to it changes nothing.
- R10: A lookup issued in the same cycle as a register write is decoded with the configuration from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 5 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_sel) |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_addr | input | 32 | Lookup address |
| res_valid | output | 1 | Result valid |
| res_miss | output | 1 | No permitted window matched |
| res_win | output | 3 | Winning window index |
| res_attr | output | 8 | Winning window attribute |

## Verification
A register write and a lookup can fall in the same clock cycle. To provoke this, the bench asserts the control-word write and the lookup request on the same edge: the write disables the window that the lookup targets. The result must still show a hit on that window, because decoding uses the configuration from before the write. The next lookup to the same address must miss.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;
    localparam int MAX_WIN   = 8;
    localparam int WIN_IDX_W = 3;
    localparam int GRAN_BITS = 16;   // 64 KB granule
    localparam int PERM_BASE = 16;   // permission pairs start here
    localparam int PERM_RD   = 0;
    localparam int PERM_WR   = 1;
    localparam int SEL_W     = 5;
    localparam logic [1:0] GRP_BASE = 2'b01;
    localparam logic [1:0] GRP_MASK = 2'b10;
endpackage

// File: rtl/addrwin_regs.sv
module addrwin_regs
    import addrwin_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [SEL_W-1:0]             sel,
    input  logic [31:0]                  wdata,
    output logic [31:0]                  rdata,
    output logic [31:0]                  ctrl,
    output logic [NUM_WIN-1:0][31:0]     base,
    output logic [NUM_WIN-1:0][31:0]     mask
);
    logic [31:0] ctrl_q;
    logic [NUM_WIN-1:0][31:0] base_q, mask_q;

    logic sel_ctrl, sel_base, sel_mask, idx_ok;
    assign idx_ok   = (int'(sel[2:0]) < NUM_WIN);
    assign sel_ctrl = (sel == '0);
    assign sel_base = (sel[4:3] == GRP_BASE) && idx_ok;
    assign sel_mask = (sel[4:3] == GRP_MASK) && idx_ok;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (we && sel_ctrl)
            ctrl_q <= wdata;
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i] <= '0;
                mask_q[i] <= '0;
            end else if (we && (int'(sel[2:0]) == i)) begin
                if (sel_base) base_q[i] <= wdata;
                if (sel_mask) mask_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (int'(sel[2:0]) == i) begin
                if (sel_base) rdata = base_q[i];
                if (sel_mask) rdata = mask_q[i];
            end
        end
        if (sel_ctrl) rdata = ctrl_q;
    end

    assign ctrl = ctrl_q;
    assign base = base_q;
    assign mask = mask_q;
endmodule

// File: rtl/addrwin_match.sv
module addrwin_match
    import addrwin_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic [31:0]              addr,
    input  logic [NUM_WIN-1:0]       en,
    input  logic [NUM_WIN-1:0][31:0] base,
    input  logic [NUM_WIN-1:0][31:0] mask,
    output logic [NUM_WIN-1:0]       match
);
    localparam int HI_W = 32 - GRAN_BITS;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        logic [HI_W-1:0] care, diff;
        assign care     = ~mask[i][31:GRAN_BITS];
        assign diff     = addr[31:GRAN_BITS] ^ base[i][31:GRAN_BITS];
        assign match[i] = en[i] && ((diff & care) == '0);
    end
endmodule

// File: rtl/addrwin_pick.sv
module addrwin_pick
    import addrwin_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic [NUM_WIN-1:0]   req,
    output logic [NUM_WIN-1:0]   gnt,
    output logic [WIN_IDX_W-1:0] idx,
    output logic                 any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = WIN_IDX_W'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/addrwin_decoder.sv
module addrwin_decoder
    import addrwin_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [4:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        lk_valid,
    input  logic        lk_write,
    input  logic [31:0] lk_addr,
    output logic        res_valid,
    output logic        res_miss,
    output logic [2:0]  res_win,
    output logic [7:0]  res_attr
);
    logic [31:0]              ctrl_w;
    logic [NUM_WIN-1:0][31:0] base_w, mask_w;
    logic [NUM_WIN-1:0]       match, gnt;
    logic [WIN_IDX_W-1:0]     idx;
    logic                     any, allowed, miss_c;
    logic [1:0]               perm;

    addrwin_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .rdata(cfg_rdata),
        .ctrl(ctrl_w), .base(base_w), .mask(mask_w)
    );

    addrwin_match #(.NUM_WIN(NUM_WIN)) u_match (
        .addr(lk_addr), .en(ctrl_w[NUM_WIN-1:0]),
        .base(base_w), .mask(mask_w), .match(match)
    );

    addrwin_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .req(match), .gnt(gnt), .idx(idx), .any(any)
    );

    assign perm    = ctrl_w[PERM_BASE + 2*int'(idx) +: 2];
    assign allowed = lk_write ? perm[PERM_WR] : perm[PERM_RD];
    assign miss_c  = !any || !allowed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_miss  <= 1'b1;
            res_win   <= '0;
            res_attr  <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_miss <= miss_c;
                res_win  <= miss_c ? '0 : idx;
                res_attr <= miss_c ? '0 : base_w[idx][15:8];
            end
        end
    end
endmodule

// File: rtl/addrwin_decoder_chk.sv
module addrwin_decoder_chk #(
    parameter int NW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lk_valid,
    input logic          res_valid,
    input logic          res_miss,
    input logic [2:0]    res_win,
    input logic [7:0]    res_attr,
    input logic [NW-1:0] gnt,
    input logic [31:0]   ctrl_w
);
    // R8: result strobe follows the request by one cycle
    a_r8_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);
    // R6: miss carries zero index and attribute
    a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_miss) |-> (res_win == 3'd0 && res_attr == 8'd0));
    // R5: at most one window granted
    a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R2: no enabled windows means miss
    a_r2_disabled_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(ctrl_w[NW-1:0]) == '0) |-> res_miss);
endmodule

bind addrwin_decoder addrwin_decoder_chk #(.NW(NUM_WIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .res_valid(res_valid),
    .res_miss(res_miss), .res_win(res_win), .res_attr(res_attr),
    .gnt(gnt), .ctrl_w(ctrl_w)
);

// File: tb/sim_addrwin_decoder.sv
module sim_addrwin_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic       miss;
        logic [2:0] win;
        logic [7:0] attr;
        logic [7:0] req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lk_valid = 1'b0;
    logic        lk_write = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        res_valid, res_miss;
    logic [2:0]  res_win;
    logic [7:0]  res_attr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    addrwin_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
        .lk_write(lk_write), .lk_addr(lk_addr), .res_valid(res_valid),
        .res_miss(res_miss), .res_win(res_win), .res_attr(res_attr)
    );

    // monitor: pop and compare each result
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            n_tests++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R8: result with no request pending (got miss=%0b win=%0d attr=%h, expected none)",
                         res_miss, res_win, res_attr);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (res_miss !== e.miss || res_win !== e.win || res_attr !== e.attr) begin
                    n_fail++;
                    $display("FAIL R%0d: got miss=%0b win=%0d attr=%h, expected miss=%0b win=%0d attr=%h",
                             e.req, res_miss, res_win, res_attr, e.miss, e.win, e.attr);
                end
            end
        end
    end

    task automatic wr(input logic [4:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] sel, input logic [31:0] exp, input int req);
        cfg_sel = sel;
        #1;
        n_tests++;
        if (cfg_rdata !== exp) begin
            n_fail++;
            $display("FAIL R%0d: sel %0d read %h, expected %h", req, sel, cfg_rdata, exp);
        end
    endtask

    // driver: push expected item, issue one-cycle request
    task automatic look(input logic [31:0] a, input logic w, input logic m,
                        input logic [2:0] win, input logic [7:0] attr, input int req);
        exp_t e;
        e.miss = m; e.win = m ? 3'd0 : win; e.attr = m ? 8'd0 : attr; e.req = 8'(req);
        sb.push_back(e);
        lk_valid = 1'b1; lk_addr = a; lk_write = w;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_chk(5'd0, 32'h0, 1);
        rd_chk(5'd8, 32'h0, 1);
        rd_chk(5'd16, 32'h0, 1);
        look(32'h0000_0000, 1'b0, 1'b1, 3'd0, 8'h00, 1);

        wr(5'd8,  32'h0000_0E00); wr(5'd16, 32'h3FFF_0000);
        wr(5'd9,  32'h4000_0D00); wr(5'd17, 32'h3FFF_0000);
        wr(5'd10, 32'h8000_0B00); wr(5'd18, 32'h0000_0000);
        wr(5'd11, 32'hC000_0700); wr(5'd19, 32'h3FFF_0000);
        wr(5'd12, 32'h4000_1F00); wr(5'd20, 32'h000F_0000);
        rd_chk(5'd9, 32'h4000_0D00, 9);   // R9
        rd_chk(5'd20, 32'h000F_0000, 9);  // R9

        look(32'h0000_1234, 1'b0, 1'b1, 3'd0, 8'h00, 2);  // R2: all disabled

        wr(5'd0, 32'h0003_0001);
        look(32'h3FFF_FFFC, 1'b0, 1'b0, 3'd0, 8'h0E, 3);  // R3, R4
        look(32'h4000_0000, 1'b0, 1'b1, 3'd0, 8'h00, 3);  // R3 edge

        wr(5'd0, 32'h0033_0005);
        look(32'h8000_FFFF, 1'b1, 1'b0, 3'd2, 8'h0B, 3);  // R3: last byte of 64 KB
        look(32'h8001_0000, 1'b0, 1'b1, 3'd0, 8'h00, 3);  // R3: next granule

        wr(5'd0, 32'h0300_0010);
        look(32'h4000_1234, 1'b0, 1'b0, 3'd4, 8'h1F, 4);  // R4: SRAM window
        look(32'h4010_0000, 1'b0, 1'b1, 3'd0, 8'h00, 3);  // R3: past 1 MB

        wr(5'd0, 32'h030C_0012);
        look(32'h4000_1234, 1'b0, 1'b0, 3'd1, 8'h0D, 5);  // R5: lowest wins

        wr(5'd0, 32'h0304_0012);
        look(32'h4000_1234, 1'b1, 1'b1, 3'd0, 8'h00, 7);  // R7, R6: no fall-through
        look(32'h4000_1234, 1'b0, 1'b0, 3'd1, 8'h0D, 7);  // R7: read allowed

        // R10: write and lookup in the same cycle
        begin
            exp_t e;
            e.miss = 1'b0; e.win = 3'd1; e.attr = 8'h0D; e.req = 8'd10;
            sb.push_back(e);
            cfg_we = 1'b1; cfg_sel = 5'd0; cfg_wdata = 32'h0;
            lk_valid = 1'b1; lk_addr = 32'h4000_1234; lk_write = 1'b0;
            @(negedge clk);
            cfg_we = 1'b0; lk_valid = 1'b0;
        end
        look(32'h4000_1234, 1'b0, 1'b1, 3'd0, 8'h00, 10);

        // R9: unmapped select
        wr(5'd5, 32'hFFFF_FFFF);
        rd_chk(5'd5, 32'h0, 9);
        rd_chk(5'd0, 32'h0, 9);

        // R8: back-to-back then idle
        wr(5'd0, 32'h0033_0005);
        look(32'h0000_0040, 1'b1, 1'b0, 3'd0, 8'h0E, 8);
        look(32'h8000_0000, 1'b0, 1'b0, 3'd2, 8'h0B, 8);
        @(negedge clk);
        n_tests++;
        if (res_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R8: res_valid got %0b, expected 0 in idle cycle", res_valid);
        end
        n_tests++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R8: %0d results missing, expected 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule